// File: doc/BRIEF.md
# Interrupt Redirection Router with Lowest-Priority Delivery

The router sits between a handful of external interrupt pins and a small group of processors. Every pin owns one redirection entry. The entry gives the vector to deliver, an encoded delivery mode, the addressing style and destination, the active level and trigger kind of the pin, a mask, and an affinity bitmask that limits which processors may take the pin. The router registers and conditions the pins and turns each qualifying assertion into a delivery message. That message carries the vector, the mode, the source pin and a processor target mask.

Most delivery modes send to every processor that passes the destination and affinity filters. The lowest-priority mode is different. Each processor drives a live task-priority value, and in that mode the router sends to the one eligible processor whose value is smallest at the moment of arbitration. For a level-triggered pin, a remote request bit is set when the message goes out. That bit stops any further delivery of the pin until an end-of-interrupt naming the same vector clears it. Software can read each pin's remote request bit and its delivery status bit, but it cannot write them.

Top module: `irq_redirect_router`

## Requirements
- R1: After reset every entry reads back with only the mask field set, both status bits read 0, and no message is issued.
- R2: Entry layout on `cfg_wdata`, bits 26:0: vector 7:0, delivery mode 10:8, destination mode 11 (0 physical, 1 logical), polarity 12 (0 active high, 1 active low), trigger 13 (0 edge, 1 level), mask 14 (1 suppresses), destination 22:15, affinity 26:23 (bit i allows processor i). `cfg_rdata` for the entry at `cfg_idx` returns the entry in bits 28:2, the remote request bit in bit 1 and the delivery status bit in bit 0. Software cannot write the two status bits.
- R3: An edge pin produces exactly one message per transition into its active level. The active level is high for polarity 0 and low for polarity 1. Holding the active level, or returning to idle, produces nothing. The message appears by the third clock edge after the pin changes and `msg_valid` stays high for a single cycle.
- R4: A masked pin issues no message. An edge that arrives while the pin is masked is dropped, so unmasking the pin while it is still held active sends nothing.
- R5: Physical addressing selects the processor whose index equals the destination field. Logical addressing treats destination bit i as a select for processor i. A processor is eligible only if it is selected and its affinity bit is set. Modes other than lowest priority target all eligible processors. The message carries the entry's vector and mode and the pin index.
- R6: In lowest-priority mode (mode 1) the target mask is one-hot on the eligible processor with the smallest `cpu_prio` value, sampled in the arbitration cycle. Ties go to the lowest processor index.
- R7: A level pin sets its remote request bit on delivery and issues no further message while that bit is set. An end-of-interrupt with a different vector leaves the bit alone. An end-of-interrupt with the pin's vector clears it, and the pin is delivered again if it is still active.
- R8: A pending pin with no eligible processor sends nothing and keeps its delivery status bit at 1. It is delivered once an entry rewrite makes a processor eligible.
- R9: When several pins are ready in the same cycle, the lowest pin index is delivered first and the others follow one per cycle.
- R10: Mode codes 0 fixed, 1 lowest priority, 2 system management, 4 non-maskable, 5 init and 7 external legacy are deliverable. The reserved codes 3 and 6 are never delivered, and a pin in a reserved mode is held pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the entry at `cfg_idx` |
| cfg_idx | input | 2 | Entry index for write and read |
| cfg_wdata | input | 27 | Entry write data |
| cfg_rdata | output | 29 | Entry and status readback |
| irq_pins | input | 4 | Raw external interrupt pins |
| cpu_prio | input | 32 | Task-priority values, processor i in bits 8i+7:8i |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being completed |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_vector | output | 8 | Delivered vector |
| msg_mode | output | 3 | Delivered mode code |
| msg_targets | output | 4 | Processor target mask |
| msg_pin | output | 2 | Source pin index |

## Verification
The bench walks a table of priority and affinity patterns that covers ties, a minimum at the top index and minima hidden behind the affinity mask. An arbiter that broke ties upward, or that ignored affinity, would pick the wrong one-hot target. Directed cases check three things: that an end-of-interrupt for the wrong vector leaves a level pin blocked while the right one re-delivers a pin still held active; that an edge seen while masked is dropped and not replayed on unmask; and that an active-low edge fires on the falling transition only. A design that held no state for unroutable or reserved-mode pins would lose the message, and one that ordered simultaneous pins wrongly would show the higher pin first.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

    localparam int VEC_W  = 8;
    localparam int DEST_W = 8;
    localparam int CPU_N  = 4;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] DM_FIXED  = 3'd0;
    localparam logic [MODE_W-1:0] DM_LOWEST = 3'd1;
    localparam logic [MODE_W-1:0] DM_RSV_A  = 3'd3;
    localparam logic [MODE_W-1:0] DM_RSV_B  = 3'd6;

    typedef struct packed {
        logic [CPU_N-1:0]  affinity;
        logic [DEST_W-1:0] dest;
        logic              mask;
        logic              trigger;    // 1 = level
        logic              polarity;   // 1 = active low
        logic              dest_mode;  // 1 = logical
        logic [MODE_W-1:0] mode;
        logic [VEC_W-1:0]  vector;
    } rt_entry_t;

    localparam int ENTRY_W = $bits(rt_entry_t);

    function automatic logic mode_deliverable(input logic [MODE_W-1:0] m);
        return (m != DM_RSV_A) && (m != DM_RSV_B);
    endfunction

    function automatic rt_entry_t entry_at_reset();
        rt_entry_t e;
        e      = '0;
        e.mask = 1'b1;
        return e;
    endfunction

endpackage

// File: rtl/irq_pin_cond.sv
module irq_pin_cond (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    input  logic active_low,
    output logic active,
    output logic went_active
);
    logic pin_q;
    logic active_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q       <= 1'b0;
            active_prev <= 1'b0;
        end else begin
            pin_q       <= pin_raw;
            active_prev <= active;
        end
    end

    assign active      = pin_q ^ active_low;
    assign went_active = active & ~active_prev;
endmodule

// File: rtl/irq_target_sel.sv
module irq_target_sel
    import irq_rt_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  rt_entry_t                 entry,
    input  logic [CPU_N*PRIO_W-1:0]   cpu_prio,
    output logic [CPU_N-1:0]          targets,
    output logic                      any_eligible
);
    localparam int CIDX_W = (CPU_N > 1) ? $clog2(CPU_N) : 1;

    logic [CPU_N-1:0]  eligible;
    logic [CPU_N-1:0]  lowest_hot;
    logic [CIDX_W-1:0] best_idx;
    logic [PRIO_W-1:0] best_prio;
    logic              found;

    for (genvar i = 0; i < CPU_N; i++) begin : g_elig
        logic selected;
        assign selected    = entry.dest_mode ? entry.dest[i]
                                             : (entry.dest == DEST_W'(i));
        assign eligible[i] = selected & entry.affinity[i];
    end

    always_comb begin
        found     = 1'b0;
        best_idx  = '0;
        best_prio = '0;
        for (int i = 0; i < CPU_N; i++) begin
            if (eligible[i] && (!found || (cpu_prio[i*PRIO_W +: PRIO_W] < best_prio))) begin
                found     = 1'b1;
                best_idx  = CIDX_W'(i);
                best_prio = cpu_prio[i*PRIO_W +: PRIO_W];
            end
        end
        lowest_hot           = '0;
        lowest_hot[best_idx] = found;
    end

    assign targets      = (entry.mode == DM_LOWEST) ? lowest_hot : eligible;
    assign any_eligible = |eligible;
endmodule

// File: rtl/irq_pin_arb.sv
module irq_pin_arb #(
    parameter int NUM_PINS = 4,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [NUM_PINS-1:0] req,
    output logic [NUM_PINS-1:0] grant,
    output logic [IDX_W-1:0]    grant_idx,
    output logic                grant_any
);
    always_comb begin
        grant_idx = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (req[i]) grant_idx = IDX_W'(i);
        end
    end

    assign grant     = req & (~req + 1'b1);
    assign grant_any = |req;
endmodule

// File: rtl/irq_redirect_router.sv
module irq_redirect_router
    import irq_rt_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int PRIO_W   = 8,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [ENTRY_W-1:0]        cfg_wdata,
    output logic [ENTRY_W+1:0]        cfg_rdata,
    input  logic [NUM_PINS-1:0]       irq_pins,
    input  logic [CPU_N*PRIO_W-1:0]   cpu_prio,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    output logic                      msg_valid,
    output logic [VEC_W-1:0]          msg_vector,
    output logic [MODE_W-1:0]         msg_mode,
    output logic [CPU_N-1:0]          msg_targets,
    output logic [IDX_W-1:0]          msg_pin
);
    rt_entry_t             entries [NUM_PINS];
    logic [NUM_PINS-1:0]   ds_q;
    logic [NUM_PINS-1:0]   rirr_q;
    logic [NUM_PINS-1:0]   pin_act;
    logic [NUM_PINS-1:0]   pin_rise;
    logic [NUM_PINS-1:0]   has_target;
    logic [NUM_PINS-1:0]   ready;
    logic [NUM_PINS-1:0]   deliver;
    logic [NUM_PINS-1:0]   eoi_hit;
    logic [NUM_PINS-1:0]   mask_vec;
    logic [NUM_PINS-1:0]   lvl_vec;
    logic [CPU_N-1:0]      tgt [NUM_PINS];
    logic [IDX_W-1:0]      grant_idx;
    logic                  grant_any;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        irq_pin_cond u_cond (
            .clk         (clk),
            .rst         (rst),
            .pin_raw     (irq_pins[p]),
            .active_low  (entries[p].polarity),
            .active      (pin_act[p]),
            .went_active (pin_rise[p])
        );

        irq_target_sel #(.PRIO_W(PRIO_W)) u_sel (
            .entry        (entries[p]),
            .cpu_prio     (cpu_prio),
            .targets      (tgt[p]),
            .any_eligible (has_target[p])
        );

        assign mask_vec[p] = entries[p].mask;
        assign lvl_vec[p]  = entries[p].trigger;
        assign eoi_hit[p]  = eoi_valid && entries[p].trigger
                             && (entries[p].vector == eoi_vector);
        assign ready[p]    = ds_q[p] && !entries[p].mask && has_target[p]
                             && mode_deliverable(entries[p].mode);

        always_ff @(posedge clk) begin
            if (rst) begin
                entries[p] <= entry_at_reset();
                ds_q[p]    <= 1'b0;
                rirr_q[p]  <= 1'b0;
            end else begin
                if (cfg_we && (cfg_idx == IDX_W'(p)))
                    entries[p] <= rt_entry_t'(cfg_wdata);
                if (entries[p].trigger) begin
                    ds_q[p]   <= pin_act[p] & ~entries[p].mask & ~rirr_q[p] & ~deliver[p];
                    rirr_q[p] <= (rirr_q[p] | deliver[p]) & ~eoi_hit[p];
                end else begin
                    ds_q[p]   <= (ds_q[p] & ~deliver[p]) | (pin_rise[p] & ~entries[p].mask);
                    rirr_q[p] <= 1'b0;
                end
            end
        end
    end

    irq_pin_arb #(.NUM_PINS(NUM_PINS)) u_arb (
        .req       (ready),
        .grant     (deliver),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid   <= 1'b0;
            msg_vector  <= '0;
            msg_mode    <= '0;
            msg_targets <= '0;
            msg_pin     <= '0;
        end else begin
            msg_valid <= grant_any;
            if (grant_any) begin
                msg_vector  <= entries[grant_idx].vector;
                msg_mode    <= entries[grant_idx].mode;
                msg_targets <= tgt[grant_idx];
                msg_pin     <= grant_idx;
            end
        end
    end

    assign cfg_rdata = {entries[cfg_idx], rirr_q[cfg_idx], ds_q[cfg_idx]};
endmodule

// File: rtl/irq_redirect_router_chk.sv
module irq_redirect_router_chk
    import irq_rt_pkg::*;
#(
    parameter int NUM_PINS = 4,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                msg_valid,
    input logic [MODE_W-1:0]   msg_mode,
    input logic [CPU_N-1:0]    msg_targets,
    input logic [IDX_W-1:0]    msg_pin,
    input logic [NUM_PINS-1:0] deliver,
    input logic [NUM_PINS-1:0] rirr,
    input logic [NUM_PINS-1:0] pin_level,
    input logic [NUM_PINS-1:0] pin_mask,
    input logic                eoi_valid
);
    logic [NUM_PINS-1:0] mask_d;

    always_ff @(posedge clk) begin
        if (rst) mask_d <= '1;
        else     mask_d <= pin_mask;
    end

    p_lowest_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_mode == DM_LOWEST) |-> $countones(msg_targets) == 1);

    p_targets_nonempty_r8: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> msg_targets != '0);

    p_mode_legal_r10: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_mode != DM_RSV_A && msg_mode != DM_RSV_B));

    p_unmasked_src_r4: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !mask_d[msg_pin]);

    p_single_grant_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(deliver));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_lvl
        p_remote_sets_r7: assert property (@(posedge clk) disable iff (rst)
            (deliver[p] && pin_level[p] && !eoi_valid) |=> rirr[p]);

        p_remote_blocks_r7: assert property (@(posedge clk) disable iff (rst)
            rirr[p] |-> !deliver[p]);
    end
endmodule

bind irq_redirect_router irq_redirect_router_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .msg_valid   (msg_valid),
    .msg_mode    (msg_mode),
    .msg_targets (msg_targets),
    .msg_pin     (msg_pin),
    .deliver     (deliver),
    .rirr        (rirr_q),
    .pin_level   (lvl_vec),
    .pin_mask    (mask_vec),
    .eoi_valid   (eoi_valid)
);

// File: tb/irq_redirect_router_tb_top.sv
module irq_redirect_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [26:0] cfg_wdata = '0;
    logic [28:0] cfg_rdata;
    logic [3:0]  irq_pins = '0;
    logic [31:0] cpu_prio = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_mode;
    logic [3:0]  msg_targets;
    logic [1:0]  msg_pin;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    irq_redirect_router dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_pins(irq_pins),
        .cpu_prio(cpu_prio), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_targets(msg_targets), .msg_pin(msg_pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {prio3, prio2, prio1, prio0, affinity, expected one-hot target}
    localparam logic [39:0] LP_VEC [8] = '{
        {8'd40,  8'd30,  8'd20,  8'd10,  4'hF,    4'b0001},
        {8'd10,  8'd20,  8'd30,  8'd40,  4'hF,    4'b1000},
        {8'd5,   8'd5,   8'd5,   8'd5,   4'hF,    4'b0001},
        {8'd7,   8'd3,   8'd3,   8'd9,   4'hF,    4'b0010},
        {8'd60,  8'd2,   8'd50,  8'd1,   4'b1010, 4'b0010},
        {8'd0,   8'd100, 8'd100, 8'd200, 4'b0110, 4'b0010},
        {8'd255, 8'd0,   8'd0,   8'd0,   4'b1000, 4'b1000},
        {8'd252, 8'd253, 8'd254, 8'd255, 4'hF,    4'b1000}
    };

    function automatic logic [26:0] mk(input logic [3:0] aff, input logic [7:0] dest,
                                       input logic msk, input logic trig, input logic pol,
                                       input logic dm, input logic [2:0] mode,
                                       input logic [7:0] vec);
        return {aff, dest, msk, trig, pol, dm, mode, vec};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_entry(input int idx, input logic [26:0] w);
        @(negedge clk);
        cfg_idx   = 2'(idx);
        cfg_wdata = w;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic read_entry(input int idx, output logic [28:0] r);
        @(negedge clk);
        cfg_idx = 2'(idx);
        #1;
        r = cfg_rdata;
    endtask

    task automatic expect_msg(input string tag, input logic [3:0] t, input logic [7:0] v,
                              input logic [2:0] m, input logic [1:0] p);
        bit seen = 0;
        for (int k = 0; k < 4 && !seen; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        check(seen, {tag, " message"}, 64'(msg_valid), 64'd1);
        if (seen)
            check({msg_targets, msg_vector, msg_mode, msg_pin} == {t, v, m, p},
                  {tag, " fields"}, 64'({msg_targets, msg_vector, msg_mode, msg_pin}),
                  64'({t, v, m, p}));
    endtask

    task automatic expect_none(input int n, input string tag);
        bit bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) bad = 1;
        end
        check(!bad, {tag, " no message"}, 64'(bad), 64'd0);
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [28:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 4; i++) begin
            read_entry(i, rd);
            check(rd == {mk(4'h0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00), 2'b00},
                  "R1 reset entry", 64'(rd),
                  64'({mk(4'h0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h00), 2'b00}));
        end
        check(msg_valid == 1'b0, "R1 reset msg_valid", 64'(msg_valid), 64'd0);

        // R2 readback layout
        write_entry(1, mk(4'b0101, 8'h9C, 1'b1, 1'b1, 1'b0, 1'b1, 3'd5, 8'hA7));
        read_entry(1, rd);
        check(rd == {mk(4'b0101, 8'h9C, 1'b1, 1'b1, 1'b0, 1'b1, 3'd5, 8'hA7), 2'b00},
              "R2 readback", 64'(rd),
              64'({mk(4'b0101, 8'h9C, 1'b1, 1'b1, 1'b0, 1'b1, 3'd5, 8'hA7), 2'b00}));

        // R6 lowest-priority table on pin 0
        for (int k = 0; k < 8; k++) begin
            cpu_prio = LP_VEC[k][39:8];
            write_entry(0, mk(LP_VEC[k][7:4], 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1,
                              8'(8'h30 + k)));
            irq_pins[0] = 1'b1;
            expect_msg($sformatf("R6 vec%0d", k), LP_VEC[k][3:0], 8'(8'h30 + k), 3'd1, 2'd0);
            @(negedge clk);
            irq_pins[0] = 1'b0;
            expect_none(3, "R3 idle after edge");
        end

        // R3 single-cycle pulse and no repeat while held
        write_entry(0, mk(4'hF, 8'h04, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h3F));
        irq_pins[0] = 1'b1;
        expect_msg("R3 rising edge", 4'b0100, 8'h3F, 3'd0, 2'd0);
        @(negedge clk);
        check(msg_valid == 1'b0, "R3 one-cycle pulse", 64'(msg_valid), 64'd0);
        expect_none(5, "R3 held active");
        irq_pins[0] = 1'b0;
        expect_none(3, "R3 back to idle");

        // R8 no eligible processor, then R5 physical delivery after rewrite
        write_entry(1, mk(4'b1011, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h41));
        irq_pins[1] = 1'b1;
        expect_none(6, "R8 unroutable");
        read_entry(1, rd);
        check(rd[0] == 1'b1, "R8 status held", 64'(rd[0]), 64'd1);
        write_entry(1, mk(4'b1111, 8'h02, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h41));
        expect_msg("R8 R5 physical after rewrite", 4'b0100, 8'h41, 3'd0, 2'd1);
        read_entry(1, rd);
        check(rd[0] == 1'b0, "R8 status cleared", 64'(rd[0]), 64'd0);
        irq_pins[1] = 1'b0;
        expect_none(3, "R5 idle");

        // R5 logical destination filtered by affinity
        write_entry(1, mk(4'b0111, 8'b0000_1011, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h42));
        irq_pins[1] = 1'b1;
        expect_msg("R5 logical", 4'b0011, 8'h42, 3'd0, 2'd1);
        @(negedge clk);
        irq_pins[1] = 1'b0;
        expect_none(3, "R5 idle");

        // R4 mask
        write_entry(2, mk(4'hF, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 3'd0, 8'h52));
        irq_pins[2] = 1'b1;
        expect_none(5, "R4 masked edge");
        write_entry(2, mk(4'hF, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h52));
        expect_none(5, "R4 unmask while held");
        irq_pins[2] = 1'b0;
        expect_none(2, "R4 idle");
        irq_pins[2] = 1'b1;
        expect_msg("R4 fresh edge", 4'b0001, 8'h52, 3'd0, 2'd2);
        @(negedge clk);
        irq_pins[2] = 1'b0;
        expect_none(3, "R4 idle");

        // R3 active-low edge
        irq_pins[3] = 1'b1;
        expect_none(2, "R3 setup");
        write_entry(3, mk(4'hF, 8'h08, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 8'h70));
        expect_none(3, "R3 active-low idle high");
        irq_pins[3] = 1'b0;
        expect_msg("R3 falling edge", 4'b1000, 8'h70, 3'd0, 2'd3);
        expect_none(4, "R3 held low");
        irq_pins[3] = 1'b1;
        expect_none(4, "R3 rising ignored");

        // R7 level with remote request
        write_entry(2, mk(4'hF, 8'h01, 1'b0, 1'b1, 1'b0, 1'b1, 3'd0, 8'h60));
        irq_pins[2] = 1'b1;
        expect_msg("R7 level first", 4'b0001, 8'h60, 3'd0, 2'd2);
        expect_none(6, "R7 blocked");
        read_entry(2, rd);
        check(rd[1] == 1'b1, "R7 remote set", 64'(rd[1]), 64'd1);
        @(negedge clk);
        eoi_vector = 8'h61; eoi_valid = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0;
        expect_none(5, "R7 wrong vector eoi");
        read_entry(2, rd);
        check(rd[1] == 1'b1, "R7 remote kept", 64'(rd[1]), 64'd1);
        @(negedge clk);
        eoi_vector = 8'h60; eoi_valid = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0;
        expect_msg("R7 redeliver", 4'b0001, 8'h60, 3'd0, 2'd2);
        @(negedge clk);
        irq_pins[2] = 1'b0;
        eoi_vector = 8'h60; eoi_valid = 1'b1;
        @(negedge clk);
        eoi_valid = 1'b0;
        expect_none(5, "R7 released");
        read_entry(2, rd);
        check(rd[1:0] == 2'b00, "R7 remote cleared", 64'(rd[1:0]), 64'd0);

        // R9 simultaneous pins
        write_entry(0, mk(4'hF, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h50));
        write_entry(1, mk(4'hF, 8'h02, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0, 8'h51));
        irq_pins[1:0] = 2'b11;
        expect_msg("R9 first pin0", 4'b0001, 8'h50, 3'd0, 2'd0);
        @(negedge clk);
        check(msg_valid && msg_pin == 2'd1 && msg_vector == 8'h51 && msg_targets == 4'b0010,
              "R9 second pin1", 64'({msg_valid, msg_pin, msg_vector}), 64'({1'b1, 2'd1, 8'h51}));
        @(negedge clk);
        check(msg_valid == 1'b0, "R9 done", 64'(msg_valid), 64'd0);
        irq_pins[1:0] = 2'b00;
        expect_none(3, "R9 idle");

        // R10 reserved mode held, then non-maskable mode delivered
        write_entry(0, mk(4'hF, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd3, 8'h55));
        irq_pins[0] = 1'b1;
        expect_none(5, "R10 reserved mode");
        read_entry(0, rd);
        check(rd[0] == 1'b1, "R10 reserved held", 64'(rd[0]), 64'd1);
        write_entry(0, mk(4'hF, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 3'd4, 8'h55));
        expect_msg("R10 nmi mode", 4'b0001, 8'h55, 3'd4, 2'd0);
        @(negedge clk);
        irq_pins[0] = 1'b0;
        expect_none(3, "R10 idle");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule